// File: doc/BRIEF.md
# High-Voltage Supply Supervisory Sequencer

This block sequences and guards an electrostatic high-voltage supply. After reset it steps the gate-driver PWM duty up over a fixed number of cycles. It then spends one cycle latching the upper and lower voltage limits, and waits until the 24 V supply has been present without a break for a set number of cycles. Once the supply is stable, it regulates toward the requested set-point with a saturating proportional duty update.

Safety interlocks act directly on the outputs. While the 24 V status is low, the PWM enable, the duty and the effective set-point are all zero in the same cycle. When power returns, regulation starts again from zero duty. A limit breach, a supply-undervoltage report or a watchdog fault latches the block into an error state with high voltage disabled. The error state is left only through an acknowledge that arrives while both the requested set-point and the measured voltage are zero. An accepted acknowledge returns the block to the 24 V wait without a new ramp.

Top module: `hv_supervisor`

## Requirements
- R1: While reset is asserted and right after it is released, the state output is 0 (ramp), the error flag is 0, the effective set-point is 0 and the duty is 0.
- R2: In the ramp state (code 0), the duty `k` cycles after reset is `k * 2^(DUTY_W - log2(RAMP_STEPS))`, with PWM enabled if 24 V is on. After RAMP_STEPS cycles the state becomes 1 (init) for one cycle, during which the limit inputs are captured. The state then becomes 2 (wait).
- R3: From wait, the state becomes 3 (closed loop) one cycle after the 24 V input has been sampled high on STABLE_CYCLES consecutive clock edges and is still high. A low sample restarts the count.
- R4: In closed loop with 24 V on, each clock applies `duty += floor((sp_i - meas_i) / 2^GAIN_SHIFT)` and saturates the result to the range 0 to 2^DUTY_W-1. The duty is 0 in the first closed-loop cycle.
- R5: The effective set-point equals `sp_i` only in closed loop with 24 V on. It is 0 in every other state.
- R6: While the 24 V input is low, `pwm_en_o`, `pwm_duty_o` and `sp_eff_o` are 0 in that same cycle. Closed loop then falls back to wait on the next clock, and the duty restarts from 0 when closed loop is re-entered.
- R7: In closed loop, a measured voltage strictly above the captured upper limit or strictly below the captured lower limit moves the state to 4 (error) on the next clock and sets `err_o`. A value equal to either limit does not.
- R8: An undervoltage report or a watchdog fault moves any state, error included, to error on the next clock. This takes precedence over every other transition, including an acknowledge.
- R9: In error, the PWM is disabled and the effective set-point is 0.
- R10: In error, an acknowledge moves the state to wait only when `sp_i` and `meas_i` are both 0. Otherwise the state stays in error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sp_i | input | SP_W | Requested voltage set-point |
| meas_i | input | SP_W | Measured high voltage |
| lim_hi_i | input | SP_W | Upper voltage limit, captured in init |
| lim_lo_i | input | SP_W | Lower voltage limit, captured in init |
| pwr24_i | input | 1 | 24 V supply present |
| uv_i | input | 1 | Supply voltage below threshold |
| wdog_i | input | 1 | Watchdog fault |
| ack_i | input | 1 | Error acknowledge strobe |
| pwm_en_o | output | 1 | PWM drive enable |
| pwm_duty_o | output | DUTY_W | PWM duty |
| sp_eff_o | output | SP_W | Effective set-point |
| state_o | output | 3 | State code: 0 ramp, 1 init, 2 wait, 3 closed loop, 4 error |
| err_o | output | 1 | Error state flag |

## Verification
The bench builds the block with 8-bit set-point and duty, RAMP_STEPS=8, STABLE_CYCLES=3 and GAIN_SHIFT=2. With these values every ramp step, every count length of the stability filter and the saturation of the duty at both ends can be reached in a few cycles. The duty update is swept over set-point and measurement pairs that give positive, negative, floored and zero steps. The acknowledge condition is checked over every zero and non-zero combination of set-point and measurement. An undervoltage or watchdog fault is injected from each of the five states.

// File: rtl/hv_sup_pkg.sv
package hv_sup_pkg;
  typedef enum logic [2:0] {
    ST_RAMP   = 3'd0,
    ST_INIT   = 3'd1,
    ST_WAIT   = 3'd2,
    ST_CLOSED = 3'd3,
    ST_ERR    = 3'd4
  } hv_state_e;
endpackage

// File: rtl/hv_pwr_qual.sv
module hv_pwr_qual #(
  parameter int STABLE_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_i,
  output logic stable_o
);
  localparam int CW = $clog2(STABLE_CYCLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(STABLE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!pwr_i)      cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  assign stable_o = (cnt_q == CMAX) && pwr_i;

  // R3
  stable_needs_history_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stable_o |-> $past(pwr_i));
endmodule

// File: rtl/hv_ramp_gen.sv
module hv_ramp_gen #(
  parameter int RAMP_STEPS = 64,
  parameter int DUTY_W     = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              done_o
);
  localparam int RW    = $clog2(RAMP_STEPS);
  localparam int SHIFT = DUTY_W - RW;
  localparam logic [RW-1:0] LAST = RW'(RAMP_STEPS - 1);

  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
    else             cnt_q <= '0;
  end

  assign duty_o = DUTY_W'(cnt_q) << SHIFT;
  assign done_o = run_i && (cnt_q == LAST);

  // R2
  ramp_monotonic_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !done_o) |=> (duty_o > $past(duty_o)) || !run_i);
endmodule

// File: rtl/hv_duty_reg.sv
module hv_duty_reg #(
  parameter int SP_W       = 12,
  parameter int DUTY_W     = 10,
  parameter int GAIN_SHIFT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [SP_W-1:0]   meas_i,
  output logic [DUTY_W-1:0] duty_o
);
  localparam int SW = ((DUTY_W > SP_W) ? DUTY_W : SP_W) + 2;
  localparam logic signed [SW-1:0] DMAX_S = SW'((1 << DUTY_W) - 1);

  logic [DUTY_W-1:0]       duty_q;
  logic signed [SP_W:0]    diff_s;
  logic signed [SP_W:0]    shf_s;
  logic signed [SW-1:0]    step_s;
  logic signed [SW-1:0]    sum_s;
  logic [DUTY_W-1:0]       duty_d;

  always_comb begin
    diff_s = $signed({1'b0, sp_i}) - $signed({1'b0, meas_i});
    shf_s  = diff_s >>> GAIN_SHIFT;
    step_s = {{(SW-SP_W-1){shf_s[SP_W]}}, shf_s};
    sum_s  = $signed({{(SW-DUTY_W){1'b0}}, duty_q}) + step_s;
    if (sum_s[SW-1])        duty_d = '0;
    else if (sum_s > DMAX_S) duty_d = DMAX_S[DUTY_W-1:0];
    else                    duty_d = sum_s[DUTY_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    duty_q <= '0;
    else if (en_i)  duty_q <= duty_d;
    else            duty_q <= '0;
  end

  assign duty_o = duty_q;

  // R6
  no_residual_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> duty_o == '0);
endmodule

// File: rtl/hv_seq_fsm.sv
module hv_seq_fsm
  import hv_sup_pkg::*;
#(
  parameter int SP_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ramp_done_i,
  input  logic            pwr_i,
  input  logic            pwr_ok_i,
  input  logic            uv_i,
  input  logic            wdog_i,
  input  logic            ack_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic [SP_W-1:0] meas_i,
  input  logic [SP_W-1:0] lim_hi_i,
  input  logic [SP_W-1:0] lim_lo_i,
  output hv_state_e       state_o
);
  hv_state_e       st_q, st_d;
  logic [SP_W-1:0] hi_q, lo_q;
  logic            breach;
  logic            ack_ok;

  assign breach = (meas_i > hi_q) || (meas_i < lo_q);
  assign ack_ok = ack_i && (sp_i == '0) && (meas_i == '0);

  always_comb begin
    st_d = st_q;
    if (uv_i || wdog_i) st_d = ST_ERR;
    else begin
      unique case (st_q)
        ST_RAMP:   if (ramp_done_i) st_d = ST_INIT;
        ST_INIT:   st_d = ST_WAIT;
        ST_WAIT:   if (pwr_ok_i) st_d = ST_CLOSED;
        ST_CLOSED: if (breach) st_d = ST_ERR;
                   else if (!pwr_i) st_d = ST_WAIT;
        ST_ERR:    if (ack_ok) st_d = ST_WAIT;
        default:   st_d = ST_ERR;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_RAMP;
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_INIT) begin
        hi_q <= lim_hi_i;
        lo_q <= lim_lo_i;
      end
    end
  end

  assign state_o = st_q;

  // R8
  fault_to_error_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i || wdog_i) |=> state_o == ST_ERR);
  // R3
  closed_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_CLOSED && $past(state_o) != ST_CLOSED) |-> ($past(state_o) == ST_WAIT && $past(pwr_i)));
  // R10
  error_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ERR && (sp_i != '0 || meas_i != '0)) |=> state_o == ST_ERR);
endmodule

// File: rtl/hv_supervisor.sv
module hv_supervisor
  import hv_sup_pkg::*;
#(
  parameter int SP_W          = 12,
  parameter int DUTY_W        = 10,
  parameter int RAMP_STEPS    = 64,
  parameter int STABLE_CYCLES = 1000,
  parameter int GAIN_SHIFT    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SP_W-1:0]   sp_i,
  input  logic [SP_W-1:0]   meas_i,
  input  logic [SP_W-1:0]   lim_hi_i,
  input  logic [SP_W-1:0]   lim_lo_i,
  input  logic              pwr24_i,
  input  logic              uv_i,
  input  logic              wdog_i,
  input  logic              ack_i,
  output logic              pwm_en_o,
  output logic [DUTY_W-1:0] pwm_duty_o,
  output logic [SP_W-1:0]   sp_eff_o,
  output logic [2:0]        state_o,
  output logic              err_o
);
  hv_state_e         st;
  logic              pwr_ok;
  logic              ramp_done;
  logic [DUTY_W-1:0] ramp_duty;
  logic [DUTY_W-1:0] reg_duty;
  logic              in_ramp, in_cl, drive;

  assign in_ramp = (st == ST_RAMP);
  assign in_cl   = (st == ST_CLOSED);

  hv_pwr_qual #(.STABLE_CYCLES(STABLE_CYCLES)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_i(pwr24_i), .stable_o(pwr_ok)
  );

  hv_ramp_gen #(.RAMP_STEPS(RAMP_STEPS), .DUTY_W(DUTY_W)) u_ramp (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(in_ramp),
    .duty_o(ramp_duty), .done_o(ramp_done)
  );

  hv_duty_reg #(.SP_W(SP_W), .DUTY_W(DUTY_W), .GAIN_SHIFT(GAIN_SHIFT)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(in_cl && pwr24_i),
    .sp_i(sp_i), .meas_i(meas_i), .duty_o(reg_duty)
  );

  hv_seq_fsm #(.SP_W(SP_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .ramp_done_i(ramp_done),
    .pwr_i(pwr24_i), .pwr_ok_i(pwr_ok), .uv_i(uv_i), .wdog_i(wdog_i),
    .ack_i(ack_i), .sp_i(sp_i), .meas_i(meas_i),
    .lim_hi_i(lim_hi_i), .lim_lo_i(lim_lo_i), .state_o(st)
  );

  // interlock: no drive without 24 V, regardless of state
  assign drive      = pwr24_i && (in_ramp || in_cl);
  assign pwm_en_o   = drive;
  assign pwm_duty_o = !drive ? '0 : (in_ramp ? ramp_duty : reg_duty);
  assign sp_eff_o   = (pwr24_i && in_cl) ? sp_i : '0;
  assign state_o    = st;
  assign err_o      = (st == ST_ERR);

  // R6
  pwr_off_interlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr24_i |-> (!pwm_en_o && pwm_duty_o == '0 && sp_eff_o == '0));
  // R9
  err_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!pwm_en_o && sp_eff_o == '0));
endmodule

// File: tb/hv_supervisor_bench.sv
module hv_supervisor_bench;
  localparam int SP_W = 8, DUTY_W = 8, RSTEPS = 8, STABLE = 3, GSH = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [SP_W-1:0] sp_i = '0, meas_i = '0, lim_hi_i = 8'd200, lim_lo_i = '0;
  logic pwr24_i = 1'b1, uv_i = 1'b0, wdog_i = 1'b0, ack_i = 1'b0;
  logic pwm_en_o, err_o;
  logic [DUTY_W-1:0] pwm_duty_o;
  logic [SP_W-1:0] sp_eff_o;
  logic [2:0] state_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  hv_supervisor #(.SP_W(SP_W), .DUTY_W(DUTY_W), .RAMP_STEPS(RSTEPS),
    .STABLE_CYCLES(STABLE), .GAIN_SHIFT(GSH)) u_hv_supervisor (
    .clk_i(clk_i), .rst_ni(rst_ni), .sp_i(sp_i), .meas_i(meas_i),
    .lim_hi_i(lim_hi_i), .lim_lo_i(lim_lo_i), .pwr24_i(pwr24_i), .uv_i(uv_i),
    .wdog_i(wdog_i), .ack_i(ack_i), .pwm_en_o(pwm_en_o), .pwm_duty_o(pwm_duty_o),
    .sp_eff_o(sp_eff_o), .state_o(state_o), .err_o(err_o));

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    #1;
  endtask

  // pwr held high: ramp, init, wait, closed after RSTEPS+2 cycles
  task automatic to_closed_from_reset();
    pwr24_i = 1'b1;
    do_reset();
    step(RSTEPS + 2);
  endtask

  task automatic recycle_closed();
    pwr24_i = 1'b0; step(1);
    pwr24_i = 1'b1; step(STABLE + 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : main
    int sps[6]   = '{100, 10, 255, 40, 3, 7};
    int meass[6] = '{60, 50, 0, 40, 0, 50};

    // R1 reset state
    rst_ni = 1'b0; #3;
    chk("R1 state in reset", state_o, 0);
    chk("R1 err in reset", err_o, 0);
    chk("R1 sp_eff in reset", sp_eff_o, 0);
    chk("R1 duty in reset", pwm_duty_o, 0);
    step(2);
    rst_ni = 1'b1; #1;
    chk("R1 state after release", state_o, 0);

    // R2 ramp sweep
    for (int k = 0; k < RSTEPS; k++) begin
      chk("R2 ramp duty", pwm_duty_o, k * (256 / RSTEPS));
      chk("R2 ramp state", state_o, 0);
      chk("R2 ramp enable", pwm_en_o, 1);
      step(1);
    end
    chk("R2 init state", state_o, 1);
    chk("R2 init no drive", pwm_en_o, 0);
    pwr24_i = 1'b0;
    step(1);
    chk("R2 wait state", state_o, 2);
    chk("R5 sp_eff in wait", sp_eff_o, 0);

    // R3 stability count with a glitch
    sp_i = 8'd50;
    pwr24_i = 1'b1; step(2);
    pwr24_i = 1'b0; step(1);
    chk("R3 glitch keeps wait", state_o, 2);
    pwr24_i = 1'b1; step(STABLE);
    chk("R3 still wait at count", state_o, 2);
    step(1);
    chk("R3 closed after count", state_o, 3);
    chk("R5 sp_eff in closed", sp_eff_o, 50);

    // R4 regulation sweep
    for (int p = 0; p < 6; p++) begin
      int d;
      recycle_closed();
      sp_i = SP_W'(sps[p]); meas_i = SP_W'(meass[p]); #1;
      chk("R4 entry duty", pwm_duty_o, 0);
      chk("R3 closed reached", state_o, 3);
      d = 0;
      for (int j = 0; j < 6; j++) begin
        int diff;
        step(1);
        diff = sps[p] - meass[p];
        d = d + (diff >>> GSH);
        if (d < 0) d = 0;
        if (d > 255) d = 255;
        chk("R4 duty step", pwm_duty_o, d);
      end
    end

    // R6 power loss in closed loop
    sp_i = 8'd100; meas_i = 8'd60; step(1);
    chk("R6 duty before loss", (pwm_duty_o != 0) ? 1 : 0, 1);
    pwr24_i = 1'b0; #1;
    chk("R6 en same cycle", pwm_en_o, 0);
    chk("R6 duty same cycle", pwm_duty_o, 0);
    chk("R6 sp_eff same cycle", sp_eff_o, 0);
    step(1);
    chk("R6 back to wait", state_o, 2);
    pwr24_i = 1'b1; step(STABLE + 1);
    chk("R6 closed again", state_o, 3);
    chk("R6 no residual duty", pwm_duty_o, 0);

    // R7 upper limit boundary
    meas_i = 8'd200; step(1);
    chk("R7 equal upper ok", state_o, 3);
    meas_i = 8'd201; step(1);
    chk("R7 above upper", state_o, 4);
    chk("R7 err flag", err_o, 1);
    chk("R9 pwm off in error", pwm_en_o, 0);
    chk("R9 sp_eff zero in error", sp_eff_o, 0);

    // R10 ack sweep
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        if (s != 0 || m != 0) begin
          sp_i = SP_W'(s); meas_i = SP_W'(m); ack_i = 1'b1;
          step(1);
          ack_i = 1'b0;
          chk("R10 ack refused", state_o, 4);
        end
    sp_i = '0; meas_i = '0; ack_i = 1'b1; wdog_i = 1'b1;
    step(1);
    chk("R8 fault beats ack", state_o, 4);
    wdog_i = 1'b0;
    step(1);
    ack_i = 1'b0;
    chk("R10 ack accepted", state_o, 2);
    chk("R10 err cleared", err_o, 0);

    // R7 lower limit with fresh limits
    lim_lo_i = 8'd5; meas_i = 8'd5; sp_i = 8'd5;
    to_closed_from_reset();
    chk("R7 closed with lo", state_o, 3);
    meas_i = 8'd4; step(1);
    chk("R7 below lower", state_o, 4);
    lim_lo_i = '0; meas_i = '0; sp_i = '0;

    // R8 fault from every state
    for (int t = 0; t < 5; t++) begin
      pwr24_i = 1'b1;
      do_reset();
      case (t)
        0: step(2);
        1: step(RSTEPS);
        2: step(RSTEPS + 1);
        3: step(RSTEPS + 2);
        default: begin uv_i = 1'b1; step(1); uv_i = 1'b0; end
      endcase
      chk("R8 pre-fault state", state_o, t);
      if (t[0]) wdog_i = 1'b1; else uv_i = 1'b1;
      step(1);
      uv_i = 1'b0; wdog_i = 1'b0;
      chk("R8 fault to error", state_o, 4);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule